// File: doc/BRIEF.md
# Dual-Device Flash Program Sequencer

This block is a bus master that carries out write-side maintenance on a parallel NOR array. The array is made of two 16-bit devices sitting side by side on a 32-bit data path. A host hands the block one request at a time, with an opcode, an address and a data word. The block then issues the required command cycles on a simple synchronous bus, waits for the write state machine of both devices, and reports how the request ended.

A word-program request writes the program command, writes the data word, and then polls status until both devices are ready. It gives up after a bounded number of extra polls. Once both devices are ready, it reads the full status and checks it for protection or program faults. Lock and unlock requests issue a two-cycle setup/confirm pair. Whatever the outcome, the block restores read-array mode before it pulses `done` with a result code. The host can then read the array directly.

Top module: `nor_prog_seq`

## Requirements
- R1: Every command byte is issued as a single 32-bit write with the byte placed in bits [7:0] and bits [23:16] and zeros elsewhere. Every bus cycle of an operation uses the address latched with the request.
- R2: Opcode 00 (program) writes command 0x40, then writes the request's 32-bit data word unmodified.
- R3: A poll is a write of 0x70 followed by one bus read. The devices count as ready only when read bit 7 and bit 23 are both 1.
- R4: When 1+MAX_RETRIES polls all fail to see both devices ready, the operation ends with result 01 and without a full status read.
- R5: After ready is seen, the block writes 0x70 again and reads the status. If any of bits 4, 1, 20 or 17 is set, it writes 0x50 and reports result 10. Otherwise it reports result 00.
- R6: Opcode 01 (lock) writes 0x60 then 0x01. Opcode 10 (unlock) writes 0x60 then 0xD0. Both produce result 00. Opcode 11 is reserved, and a request carrying it is ignored with no bus activity.
- R7: Every operation finishes with a write of 0xFF. In the cycle after that write completes, `done` is high for exactly one cycle with `result` valid.
- R8: `req_ready` is high only while idle. A request presented while an operation is running is dropped and does not alter the bus sequence.
- R9: `bus_we` and `bus_re` are never high together. A bus access keeps its strobe, address and write data stable until a clock edge where `bus_ready` is high, and read data is taken at that edge.
- R10: After reset the block is idle, with `req_ready` high and `bus_we`, `bus_re` and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_op | input | 2 | 00 program, 01 lock, 10 unlock, 11 reserved |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | 32 | Word to program |
| req_ready | output | 1 | High while idle |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 busy timeout, 10 protection error |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_rdata | input | 32 | Bus read data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_ready | input | 1 | Access completes on an edge where high |

## Verification
The bench builds the block with MAX_RETRIES set to 5, so the poll limit is six reads. This lets it hit the exact boundary cheaply: ready appearing on the sixth poll succeeds, and ready appearing on the seventh gives a busy timeout. The bench's device model makes the two halves become ready after different poll counts, which checks that one ready half is not enough. Stalls on `bus_ready` check that accesses are held. The error bits are placed in either half.

// File: rtl/nor_prog_seq.sv
module nor_prog_seq #(
  parameter int ADDR_W      = 32,
  parameter int MAX_RETRIES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_data,
  output logic              req_ready,
  output logic              done,
  output logic [1:0]        result,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic              bus_ready
);
  localparam int CNT_W = (MAX_RETRIES < 1) ? 1 : $clog2(MAX_RETRIES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MAX_RETRIES);
  localparam logic [31:0] RDY_MASK = 32'h0080_0080;
  localparam logic [31:0] ERR_MASK = 32'h0012_0012;
  localparam logic [1:0] OP_PROG = 2'b00, OP_LOCK = 2'b01, OP_UNLK = 2'b10;
  localparam logic [1:0] RES_OK = 2'b00, RES_BUSY = 2'b01, RES_PROT = 2'b10;

  typedef enum logic [3:0] {
    S_IDLE, S_PG_CMD, S_PG_DATA, S_PL_CMD, S_PL_RD, S_ST_CMD, S_ST_RD,
    S_CLR, S_LK_CMD, S_LK_ARG, S_ARRAY, S_DONE
  } state_t;

  state_t             state;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [31:0]        data_q;
  logic [CNT_W-1:0]   tries;
  logic [1:0]         res_q;

  function automatic logic [31:0] dup(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign result    = res_q;
  assign bus_addr  = addr_q;
  assign bus_re    = (state == S_PL_RD) || (state == S_ST_RD);
  assign bus_we    = !(state == S_IDLE || state == S_DONE || bus_re);

  wire xfer = (bus_we || bus_re) && bus_ready;
  wire both_rdy = (bus_rdata & RDY_MASK) == RDY_MASK;

  always_comb begin
    case (state)
      S_PG_CMD:          bus_wdata = dup(8'h40);
      S_PG_DATA:         bus_wdata = data_q;
      S_PL_CMD, S_ST_CMD: bus_wdata = dup(8'h70);
      S_CLR:             bus_wdata = dup(8'h50);
      S_LK_CMD:          bus_wdata = dup(8'h60);
      S_LK_ARG:          bus_wdata = (op_q == OP_LOCK) ? dup(8'h01) : dup(8'hD0);
      S_ARRAY:           bus_wdata = dup(8'hFF);
      default:           bus_wdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      tries  <= '0;
      res_q  <= RES_OK;
    end else begin
      case (state)
        S_IDLE: if (req_valid && req_op != 2'b11) begin
          op_q   <= req_op;
          addr_q <= req_addr;
          data_q <= req_data;
          tries  <= CNT_LOAD;
          res_q  <= RES_OK;
          state  <= (req_op == OP_PROG) ? S_PG_CMD : S_LK_CMD;
        end
        S_PG_CMD:  if (xfer) state <= S_PG_DATA;
        S_PG_DATA: if (xfer) state <= S_PL_CMD;
        S_PL_CMD:  if (xfer) state <= S_PL_RD;
        S_PL_RD: if (xfer) begin
          if (both_rdy) state <= S_ST_CMD;
          else if (tries == '0) begin
            res_q <= RES_BUSY;
            state <= S_ARRAY;
          end else begin
            tries <= tries - 1'b1;
            state <= S_PL_CMD;
          end
        end
        S_ST_CMD: if (xfer) state <= S_ST_RD;
        S_ST_RD: if (xfer) begin
          if ((bus_rdata & ERR_MASK) != '0) begin
            res_q <= RES_PROT;
            state <= S_CLR;
          end else state <= S_ARRAY;
        end
        S_CLR:    if (xfer) state <= S_ARRAY;
        S_LK_CMD: if (xfer) state <= S_LK_ARG;
        S_LK_ARG: if (xfer) state <= S_ARRAY;
        S_ARRAY:  if (xfer) state <= S_DONE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R9
  AST_HOLD_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) && !bus_ready |=>
      $stable(bus_we) && $stable(bus_re) && $stable(bus_addr) && $stable(bus_wdata)); // R9
  AST_CMD_DUPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we && state != S_PG_DATA |-> bus_wdata[31:16] == bus_wdata[15:0] && bus_wdata[15:8] == 8'h00); // R1
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_we && bus_ready && bus_wdata == 32'h00FF_00FF)); // R7
  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> result != 2'b11); // R7
  AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_op != 2'b11 |=> !req_ready); // R8
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && !(req_valid && req_op != 2'b11) |=> req_ready && !bus_we && !bus_re); // R6
endmodule

// File: tb/tb_nor_prog_seq.sv
module tb_nor_prog_seq;
  localparam int RETRIES = 5;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic [31:0] req_addr = 0, req_data = 0;
  logic req_ready, done;
  logic [1:0] result;
  logic [31:0] bus_addr, bus_wdata, bus_rdata = 0;
  logic bus_we, bus_re, bus_ready = 0;

  nor_prog_seq #(.ADDR_W(32), .MAX_RETRIES(RETRIES)) dut (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_data, .req_ready,
    .done, .result, .bus_addr, .bus_wdata, .bus_rdata, .bus_we, .bus_re, .bus_ready);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit busy = 0, op_done = 0, stall = 0, finished = 0;
  logic [1:0] exp_res;
  logic [31:0] exp_addr;
  logic [32:0] exp_q[$];
  string exp_tag[$];
  int lo_nr, hi_nr, reads;
  logic [31:0] err_word;

  function automatic logic [31:0] dup(input logic [7:0] b);
    return {8'h00, b, 8'h00, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input bit w, input logic [31:0] v, input string tag);
    exp_q.push_back({w, v});
    exp_tag.push_back(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    bit rdy;
    cyc++;
    chk(req_ready == !busy, "R8 req_ready", {31'd0, req_ready}, {31'd0, !busy});
    if (done) begin
      chk(busy, "R7 done without operation", 1, 0);
      chk(result == exp_res, "R7 result code", {30'd0, result}, {30'd0, exp_res});
      chk(exp_q.size() == 0, "R7 done before sequence ended", exp_q.size(), 0);
      busy = 0;
      op_done = 1;
    end
    rdy = stall ? (cyc % 3 != 0) : 1'b1;
    if ((bus_we || bus_re) && rdy) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected bus access", {30'd0, bus_we, bus_re}, 0);
      end else begin
        logic [32:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        chk(bus_addr == exp_addr, {t, " R1 address"}, bus_addr, exp_addr);
        chk(bus_we == e[32] && bus_re == !e[32], {t, " access kind"}, {31'd0, bus_we}, {31'd0, e[32]});
        if (e[32]) chk(bus_wdata == e[31:0], {t, " write data"}, bus_wdata, e[31:0]);
        else begin
          logic [31:0] s;
          s = ((reads >= lo_nr) ? 32'h0000_0080 : 32'h0) | ((reads >= hi_nr) ? 32'h0080_0000 : 32'h0);
          if (s == 32'h0080_0080) s = s | err_word;
          bus_rdata = s;
          reads++;
        end
      end
    end
    bus_ready = rdy;
    if (cyc > 20000) begin
      chk(0, "watchdog", cyc, 20000);
      summary();
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] d,
                        input int lo, input int hi, input logic [31:0] ew, input bit st, input bit inject);
    int n, lim, k;
    lo_nr = lo; hi_nr = hi; err_word = ew; reads = 0; stall = st;
    exp_addr = a;
    if (op == 2'b00) begin
      push(1, dup(8'h40), "R2");
      push(1, d, "R2");
      n = ((lo > hi) ? lo : hi) + 1;
      lim = RETRIES + 1;
      if (n <= lim) begin
        for (int i = 0; i < n; i++) begin push(1, dup(8'h70), "R3"); push(0, 0, "R3"); end
        push(1, dup(8'h70), "R5"); push(0, 0, "R5");
        if ((ew & 32'h0012_0012) != 0) begin push(1, dup(8'h50), "R5"); exp_res = 2'b10; end
        else exp_res = 2'b00;
      end else begin
        for (int i = 0; i < lim; i++) begin push(1, dup(8'h70), "R4"); push(0, 0, "R4"); end
        exp_res = 2'b01;
      end
    end else begin
      push(1, dup(8'h60), "R6");
      push(1, (op == 2'b01) ? dup(8'h01) : dup(8'hD0), "R6");
      exp_res = 2'b00;
    end
    push(1, dup(8'hFF), "R7");
    @(negedge clk); #1;
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    busy = 1; op_done = 0;
    @(negedge clk); #1;
    req_valid = 0;
    k = 0;
    while (!op_done) begin
      @(negedge clk); #2;
      k++;
      if (inject && (k == 2 || k == 3)) begin
        req_valid = 1; req_op = 2'b01; req_addr = a ^ 32'h10; req_data = ~d;
      end else req_valid = 0;
    end
    req_valid = 0;
  endtask

  initial begin
    #35;
    rst_n = 1;
    @(negedge clk); #2;
    chk(req_ready && !bus_we && !bus_re && !done, "R10 reset state",
        {28'd0, req_ready, bus_we, bus_re, done}, 32'h8);
    run_op(2'b00, 32'h0000_1000, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    run_op(2'b00, 32'h0000_2004, 32'h1234_5678, 2, 4, 0, 1, 0);
    run_op(2'b00, 32'h0000_2008, 32'hA5A5_0F0F, 5, 1, 0, 0, 0);
    run_op(2'b00, 32'h0000_200C, 32'h0000_0001, 6, 0, 0, 1, 0);
    run_op(2'b00, 32'h0000_3000, 32'hFFFF_0000, 1, 1, 32'h0000_0010, 0, 0);
    run_op(2'b00, 32'h0000_3004, 32'h0F0F_F0F0, 0, 2, 32'h0002_0000, 1, 0);
    run_op(2'b01, 32'h0004_0000, 32'h0, 0, 0, 0, 0, 0);
    run_op(2'b10, 32'h0008_0000, 32'h0, 0, 0, 0, 1, 0);
    run_op(2'b00, 32'h0000_4000, 32'hCAFE_F00D, 4, 4, 0, 1, 1);
    // R6: reserved opcode leaves the block idle with no bus traffic
    @(negedge clk); #1;
    req_valid = 1; req_op = 2'b11; req_addr = 32'h5000;
    @(negedge clk); #1;
    req_valid = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #2;
      chk(req_ready && !bus_we && !bus_re && !done, "R6 reserved opcode ignored",
          {29'd0, req_ready, bus_we, bus_re}, 32'h4);
    end
    run_op(2'b01, 32'h0000_6000, 32'h0, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    #2;
    summary();
  end
endmodule